// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides which clock domains of a device keep running while the processor sleeps. Software first programs a 2-bit sleep mode, a 6-bit standby qualification code and a 16-bit mask of wake sources through a small register bus. It then executes the sleep instruction, which reaches the block as a one-cycle idle strobe. The block then enters one of three sleep states. Each state switches off a different set of four clock enables: processor, peripherals, watchdog and oscillator/PLL.

Each sleep state accepts a different set of exit events. The light state ends on a peripheral interrupt or on any enabled wake source going low. The standby state ends only when an enabled wake source has stayed low for a programmed number of oscillator cycles. The deepest state ends only on reset. On any exit, all four clock enables come back in the same cycle, together with a single-cycle wake pulse. The block runs on the oscillator clock, which is the only clock that stays alive in standby.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset (rst_n low, asynchronous) is applied and after it is released, the block is awake: all four clock enables read 1, wake_pulse is 0, and both registers read 0.
- R2: Address 0 holds the sleep mode in bits [1:0] and the qualification code in bits [7:2], with bits [15:8] reading 0. Address 1 holds the wake-source enable mask, one bit per wake_n line, where 1 enables the line. Addresses 2 and 3 read 0 and ignore writes.
- R3: When idle_req is high in the awake state and the mode is 00, the block enters the light state on the next cycle. In that state only the processor clock enable is 0. idle_req is ignored in any sleep state.
- R4: With mode 01, idle_req enters standby, in which the processor and peripheral clock enables are 0 and the watchdog and oscillator enables stay 1.
- R5: With mode 10 or 11, idle_req enters the deepest state, in which all four clock enables are 0.
- R6: In the light state, periph_irq high, or any enabled wake_n line low, returns the block to the awake state on the next cycle. Disabled wake lines have no effect.
- R7: In standby, the block wakes on the clock edge at which an enabled wake line has been sampled low on n+2 consecutive edges, where n is the qualification code. A sample with no enabled line low restarts the count. Disabled lines have no effect.
- R8: In standby, periph_irq has no effect.
- R9: In the deepest state, periph_irq and wake_n have no effect; only reset ends it.
- R10: On every exit, wake_pulse is 1 for exactly the one cycle in which the clock enables first return to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| idle_req | input | 1 | Sleep instruction strobe |
| wake_n | input | 16 | Active-low wake sources |
| periph_irq | input | 1 | Peripheral interrupt request |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wdg_clk_en | output | 1 | Watchdog clock enable |
| osc_clk_en | output | 1 | Oscillator/PLL enable |
| wake_pulse | output | 1 | One-cycle exit indication |

## Verification
The bench builds the block with its default widths: 16 wake lines and a 6-bit qualification code. These widths let it reach both ends of the qualification range, from 2 cycles for code 0 up to 65 cycles for code 63, and every position of the wake mask. Random rounds choose the mode, a small code and a random mask, and check the exact wake edge against n+2. They also inject interrupts and disabled-line activity where those events must be ignored. Directed cases cover a glitch that restarts the count, and reset as the only way out of the deepest state.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int WAKE_W = 16,
  parameter int QUAL_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              idle_req,
  input  logic [WAKE_W-1:0] wake_n,
  input  logic              periph_irq,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              wdg_clk_en,
  output logic              osc_clk_en,
  output logic              wake_pulse
);
  localparam int CNT_W = QUAL_W + 1;

  typedef enum logic [1:0] {ST_RUN, ST_IDLE, ST_STBY, ST_HALT} st_t;

  st_t               st, st_nxt;
  logic [1:0]        mode;
  logic [QUAL_W-1:0] qual;
  logic [WAKE_W-1:0] wake_en;
  logic [CNT_W-1:0]  cnt;
  logic              hit, leave;

  assign hit = |(~wake_n & wake_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      qual    <= '0;
      wake_en <= '0;
    end else if (bus_we) begin
      if (bus_addr == 2'd0) begin
        mode <= bus_wdata[1:0];
        qual <= bus_wdata[QUAL_W+1:2];
      end else if (bus_addr == 2'd1) begin
        wake_en <= bus_wdata[WAKE_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 2'd0) bus_rdata[QUAL_W+1:0] = {qual, mode};
    else if (bus_addr == 2'd1) bus_rdata[WAKE_W-1:0] = wake_en;
  end

  always_comb begin
    st_nxt = st;
    leave  = 1'b0;
    case (st)
      ST_RUN:
        if (idle_req)
          st_nxt = (mode == 2'b00) ? ST_IDLE : (mode == 2'b01) ? ST_STBY : ST_HALT;
      ST_IDLE: leave = periph_irq | hit;
      ST_STBY: leave = hit && (cnt == CNT_W'(qual) + CNT_W'(1));
      default: leave = 1'b0;
    endcase
    if (leave) st_nxt = ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_RUN;
      cnt        <= '0;
      wake_pulse <= 1'b0;
    end else begin
      st         <= st_nxt;
      wake_pulse <= leave;
      if (st != ST_STBY || !hit) cnt <= '0;
      else cnt <= cnt + CNT_W'(1);
    end
  end

  assign cpu_clk_en = (st == ST_RUN);
  assign per_clk_en = (st == ST_RUN) || (st == ST_IDLE);
  assign wdg_clk_en = (st != ST_HALT);
  assign osc_clk_en = (st != ST_HALT);

  AST_ENTRY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_RUN && st != ST_RUN) |-> $past(idle_req)); // R3
  AST_STBY_EXIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_STBY && st == ST_RUN) |-> $past(hit)); // R7
  AST_STBY_IGNORES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STBY && periph_irq && !hit) |=> (st == ST_STBY)); // R8
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALT) |=> (st == ST_HALT)); // R9
  AST_WAKE_WITH_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> wake_pulse); // R10
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R10
endmodule

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb;
  logic        clk = 0, rst_n = 0, bus_we = 0, idle_req = 0, periph_irq = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata, wake_n = 16'hFFFF;
  logic        cpu_clk_en, per_clk_en, wdg_clk_en, osc_clk_en, wake_pulse;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  lpm_ctrl u_dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idle_req(idle_req), .wake_n(wake_n),
    .periph_irq(periph_irq), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .wdg_clk_en(wdg_clk_en), .osc_clk_en(osc_clk_en), .wake_pulse(wake_pulse));

  function automatic logic [3:0] exp_en(input logic [1:0] m);
    case (m)
      2'b00: return 4'b0111;
      2'b01: return 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  function automatic logic [3:0] en(); return {cpu_clk_en, per_clk_en, wdg_clk_en, osc_clk_en}; endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d; tick(); bus_we = 0;
  endtask
  task automatic rd_check(input string req, input logic [1:0] a, input logic [15:0] e);
    bus_addr = a; #1; check(req, bus_rdata, e);
  endtask
  task automatic enter(input logic [1:0] m);
    idle_req = 1; tick(); idle_req = 0;
    check("R3/R4/R5 entry", en(), exp_en(m));
    check("R10 no pulse on entry", wake_pulse, 0);
  endtask
  task automatic expect_wake(input string req);
    check(req, {en(), wake_pulse}, 5'b11111);
    tick();
    check("R10 pulse one cycle", wake_pulse, 0);
  endtask

  task automatic stby_run(input int n, input int bitn, input bit glitch);
    wr(0, 16'((n << 2) | 1)); enter(2'b01);
    if (glitch) begin
      wake_n[bitn] = 0; repeat (n + 1) tick();
      wake_n[bitn] = 1; tick();
      check("R7 glitch restarts", en(), 4'b0011);
    end
    wake_n[bitn] = 0;
    repeat (n + 1) tick();
    check("R7 not yet qualified", en(), 4'b0011);
    tick();
    expect_wake("R7 wake at n+2");
    wake_n = 16'hFFFF;
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check("R1 enables in reset", {en(), wake_pulse}, 5'b11110);
    #10; rst_n = 1; tick();
    check("R1 enables after reset", {en(), wake_pulse}, 5'b11110);
    rd_check("R1 reg0 reset", 0, 0);
    rd_check("R1 reg1 reset", 1, 0);
    wr(0, 16'hFFFF); rd_check("R2 reg0 fields", 0, 16'h00FF);
    wr(1, 16'hA5C3); rd_check("R2 wake mask", 1, 16'hA5C3);
    wr(2, 16'h1234); rd_check("R2 addr2 reads 0", 2, 0);
    rd_check("R2 addr2 write ignored", 1, 16'hA5C3);

    // R3 light state, R6 exits
    wr(1, 16'h0001); wr(0, 16'h0000); enter(2'b00);
    idle_req = 1; tick(); idle_req = 0;
    check("R3 strobe ignored asleep", en(), 4'b0111);
    wake_n[5] = 0; tick(); wake_n = 16'hFFFF;
    check("R6 disabled line ignored", en(), 4'b0111);
    periph_irq = 1; tick(); periph_irq = 0;
    expect_wake("R6 irq wakes light state");
    enter(2'b00);
    wake_n[0] = 0; tick(); wake_n = 16'hFFFF;
    expect_wake("R6 wake line exits light state");

    // R7 standby qualification corners, R8
    stby_run(0, 0, 0);
    wr(1, 16'h8000);
    stby_run(63, 15, 0);
    stby_run(3, 15, 1);
    wr(0, 16'h0009); enter(2'b01);
    periph_irq = 1; wake_n[3] = 0; repeat (6) tick(); periph_irq = 0; wake_n = 16'hFFFF;
    check("R8 irq ignored in standby", en(), 4'b0011);
    check("R7 disabled line ignored", wake_pulse, 0);
    wake_n[15] = 0; repeat (4) tick(); wake_n = 16'hFFFF;
    expect_wake("R7 wake after ignored events");

    // R5 halt, R9
    wr(0, 16'h0002); enter(2'b10);
    periph_irq = 1; wake_n = 16'h0000; repeat (70) tick(); periph_irq = 0; wake_n = 16'hFFFF;
    check("R9 halt holds", {en(), wake_pulse}, 5'b00000);
    rst_n = 0; #1;
    check("R9 reset exits halt", en(), 4'b1111);
    rd_check("R1 reset clears mode", 0, 0);
    tick(); rst_n = 1; tick();

    // random rounds
    for (int i = 0; i < 40; i++) begin
      logic [1:0]  m = 2'($urandom % 4);
      int          n = $urandom % 8;
      int          b = $urandom % 16;
      logic [15:0] mask = 16'($urandom) | (16'd1 << b);
      wr(1, mask); wr(0, 16'((n << 2) | m)); enter(m);
      if (m == 2'b00) begin
        if ($urandom % 2) periph_irq = 1; else wake_n[b] = 0;
        tick(); periph_irq = 0; wake_n = 16'hFFFF;
        expect_wake("R6 random light exit");
      end else if (m == 2'b01) begin
        periph_irq = 1; repeat (3) tick(); periph_irq = 0;
        check("R8 random irq ignored", en(), 4'b0011);
        wake_n[b] = 0; repeat (n + 1) tick();
        check("R7 random before n+2", en(), 4'b0011);
        tick(); wake_n = 16'hFFFF;
        expect_wake("R7 random at n+2");
      end else begin
        wake_n[b] = 0; periph_irq = 1; repeat (12) tick(); wake_n = 16'hFFFF; periph_irq = 0;
        check("R5/R9 random halt holds", {en(), wake_pulse}, 5'b00000);
        rst_n = 0; tick(); rst_n = 1; tick();
        check("R1 random reset awake", {en(), wake_pulse}, 5'b11110);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end
endmodule